// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an on-chip host and an external asynchronous static RAM with a 19-bit address, an 8-bit data bus, a pair of chip selects of opposite polarity, an active-low write strobe and an active-low output strobe. The host presents one request at a time on a valid/ready interface: a direction bit, an address and, for writes, a data byte. The controller registers the request and then walks the memory pins through a fixed sequence of clocked phases. The length of each phase is derived at elaboration time from nanosecond minimums and the clock period.

Writes are framed as an overlap window. Both selects go active with the write strobe still high, and the data driver switches on. The write strobe is then held low long enough to cover the pulse width, the select-to-end and address-to-end windows, and data setup. A recovery cycle follows, in which the driver is still on, before the selects drop. Reads hold both selects and the output strobe active for the access time. The returned byte is captured on the final access cycle and handed back with a one-cycle valid pulse. A deselected turnaround then gives the memory time to release the bus before another request is taken. The data bus leaves the block as separate output, output-enable and input vectors, so that the pad ring can build the tri-state buffer.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and while idle, both selects are inactive (`sram_cs_n`=1, `sram_cs`=0), `sram_we_n`=1, `sram_oe_n`=1, `sram_dq_oe`=0, `rd_valid`=0 and `req_ready`=1.
- R2: `req_ready` is high only in the idle state. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. From the next cycle, `sram_addr` equals the accepted address. Later changes on `req_addr`/`req_wdata` have no effect on the access in progress.
- R3: During a write, `sram_we_n` is low for exactly NWP = max(1, ceil(max(tWP,tCW,tAW,tDW)/CLK_PERIOD_NS)) consecutive cycles. Both selects stay active and `sram_oe_n` stays high throughout.
- R4: The select-active window of a write lasts max(ceil(tWC/CLK_PERIOD_NS), NWP+2) cycles: one setup cycle, the strobe, then recovery. This is 11 cycles for grade 0 at 5 ns.
- R5: `sram_dq_oe` rises exactly one cycle before `sram_we_n` falls, while `sram_oe_n` is high and has been high the previous cycle. It falls one cycle after `sram_we_n` rises, with `sram_dq_o` constant while it is high. It is never high while `sram_oe_n` is low.
- R6: During a read, both selects are active and `sram_oe_n` is low for exactly NRD = max(1, ceil(max(tRC,tAA,tOE)/CLK_PERIOD_NS)) cycles. During those cycles `sram_we_n` is high, `sram_dq_oe` is low and `sram_addr` is stable.
- R7: `rd_data` holds the value present on `sram_dq_i` at the end of the last read-access cycle. `rd_valid` is high for exactly one cycle, the first cycle after `sram_oe_n` rises, which is NRD+1 cycles after acceptance.
- R8: After a read, the device stays deselected with `sram_oe_n` high for NTA = max(1, ceil(tOHZ/CLK_PERIOD_NS)) cycles, counting the `rd_valid` cycle, before `req_ready` returns.
- R9: `SPEED_GRADE`=0 selects tWC=tRC=tAA=55, tWP=40, tCW=tAW=45, tDW=25, tOE=25, tOHZ=20 ns. `SPEED_GRADE`=1 selects tWC=tRC=tAA=70, tWP=50, tCW=tAW=60, tDW=30, tOE=35, tOHZ=25 ns. At 5 ns this gives NWP/NRD/NTA of 9/11/4 for grade 0 and 12/14/5 for grade 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds read result |
| rd_data | output | DATA_W | Captured read data |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_cs_n | output | 1 | Active-low chip select |
| sram_cs | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output strobe |
| sram_dq_o | output | DATA_W | Data to drive onto the bus |
| sram_dq_oe | output | 1 | Bus driver enable |
| sram_dq_i | input | DATA_W | Data read from the bus |

## Verification
The assertions watch the pin-level rules on every cycle. The driver is never on while the output strobe is low, and it turns on only after that strobe has been high. The write strobe appears only inside an active select window with the output strobe high, and its low run has the derived length. Address and write data stay stable while they are in use, ready appears only with the pins idle, and the read-valid strobe never lasts two cycles. Only the directed scenarios, running against a memory model that returns corrupted data until the access time has passed, can show the rest. That covers the exact phase lengths of both speed grades, the read latency and turnaround count, the data that actually lands in and comes back from memory, and the fact that the host's changes after acceptance go unused.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WR_SETUP  = 3'd1,
        ST_WR_PULSE  = 3'd2,
        ST_WR_RECOV  = 3'd3,
        ST_RD_ACCESS = 3'd4,
        ST_RD_TURN   = 3'd5
    } ctrl_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Clock cycles needed to cover a nanosecond minimum, never below one.
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [DATA_W-1:0] din,
    output logic              valid,
    output logic [DATA_W-1:0] dout
);

    logic              valid_d, valid_q;
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        valid_d = strobe;
        data_d  = strobe ? din : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= valid_d;
            data_q  <= data_d;
        end
    end

    assign valid = valid_q;
    assign dout  = data_q;

    // R7: the result strobe never lasts longer than one cycle
    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 5,
    parameter int SPEED_GRADE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_cs,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);

    // Nanosecond minimums per speed grade (R9)
    localparam bit SLOW   = (SPEED_GRADE != 0);
    localparam int T_WC   = SLOW ? 70 : 55;
    localparam int T_WP   = SLOW ? 50 : 40;
    localparam int T_CW   = SLOW ? 60 : 45;
    localparam int T_AW   = SLOW ? 60 : 45;
    localparam int T_DW   = SLOW ? 30 : 25;
    localparam int T_RC   = SLOW ? 70 : 55;
    localparam int T_AA   = SLOW ? 70 : 55;
    localparam int T_OE   = SLOW ? 35 : 25;
    localparam int T_OHZ  = SLOW ? 25 : 20;

    localparam int N_WP   = ns_to_cycles(imax(imax(T_WP, T_CW), imax(T_AW, T_DW)), CLK_PERIOD_NS);
    localparam int N_WC   = ns_to_cycles(T_WC, CLK_PERIOD_NS);
    localparam int N_REC  = (N_WC > N_WP + 1) ? (N_WC - N_WP - 1) : 1;
    localparam int N_RD   = ns_to_cycles(imax(T_RC, imax(T_AA, T_OE)), CLK_PERIOD_NS);
    localparam int N_TA   = ns_to_cycles(T_OHZ, CLK_PERIOD_NS);
    localparam int N_MAX  = imax(imax(N_WP, N_REC), imax(N_RD, N_TA));
    localparam int CNT_W  = $clog2(N_MAX + 1);

    typedef struct packed {
        ctrl_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              cs_n;
        logic              cs;
        logic              we_n;
        logic              oe_n;
        logic              drv;
    } ctrl_regs_t;

    ctrl_regs_t       regs_d, regs_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             cap_strobe;
    logic             selected;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cap_strobe),
        .din    (sram_dq_i),
        .valid  (rd_valid),
        .dout   (rd_data)
    );

    always_comb begin
        regs_d     = regs_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        cap_strobe = 1'b0;

        unique case (regs_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    regs_d.addr  = req_addr;
                    regs_d.wdata = req_wdata;
                    if (req_write) begin
                        regs_d.state = ST_WR_SETUP;
                    end else begin
                        regs_d.state = ST_RD_ACCESS;
                        tmr_load     = 1'b1;
                        tmr_val      = CNT_W'(N_RD - 1);
                    end
                end
            end
            ST_WR_SETUP: begin
                regs_d.state = ST_WR_PULSE;
                tmr_load     = 1'b1;
                tmr_val      = CNT_W'(N_WP - 1);
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    regs_d.state = ST_WR_RECOV;
                    tmr_load     = 1'b1;
                    tmr_val      = CNT_W'(N_REC - 1);
                end
            end
            ST_WR_RECOV: begin
                if (tmr_expired)
                    regs_d.state = ST_IDLE;
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) begin
                    cap_strobe   = 1'b1;
                    regs_d.state = ST_RD_TURN;
                    tmr_load     = 1'b1;
                    tmr_val      = CNT_W'(N_TA - 1);
                end
            end
            ST_RD_TURN: begin
                if (tmr_expired)
                    regs_d.state = ST_IDLE;
            end
            default: regs_d.state = ST_IDLE;
        endcase

        // Pin levels follow the state being entered, so every pin is a flop.
        selected    = regs_d.state inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_RECOV, ST_RD_ACCESS};
        regs_d.cs_n = !selected;
        regs_d.cs   = selected;
        regs_d.we_n = (regs_d.state != ST_WR_PULSE);
        regs_d.oe_n = (regs_d.state != ST_RD_ACCESS);
        regs_d.drv  = (regs_d.state inside {ST_WR_SETUP, ST_WR_PULSE}) ||
                      (regs_q.state == ST_WR_PULSE && regs_d.state == ST_WR_RECOV);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.cs_n <= 1'b1;
            regs_q.we_n <= 1'b1;
            regs_q.oe_n <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign req_ready  = (regs_q.state == ST_IDLE);
    assign sram_addr  = regs_q.addr;
    assign sram_cs_n  = regs_q.cs_n;
    assign sram_cs    = regs_q.cs;
    assign sram_we_n  = regs_q.we_n;
    assign sram_oe_n  = regs_q.oe_n;
    assign sram_dq_o  = regs_q.wdata;
    assign sram_dq_oe = regs_q.drv;

    // Length of the current write-strobe low run, for the pulse-width check
    logic [CNT_W:0] we_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            we_run_q <= '0;
        else if (!sram_we_n)
            we_run_q <= we_run_q + 1'b1;
        else
            we_run_q <= '0;
    end

    // R2: ready only while every memory pin is idle
    p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_cs_n && !sram_cs && sram_we_n && sram_oe_n && !sram_dq_oe));

    // R3: write strobe only inside an active select window with outputs off
    p_we_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_cs_n && sram_cs && sram_oe_n && sram_dq_oe));

    // R3: each write strobe lasts the derived cycle count
    p_we_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_run_q == (CNT_W+1)'(N_WP)));

    // R5: the driver is never on while the memory may drive
    p_drv_oe_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    // R5: the driver turns on only after a cycle with output strobe high, before the strobe
    p_drv_turn_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> ($past(sram_oe_n) && sram_we_n));

    // R5: write data held constant while driven
    p_wdata_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o));

    // R6: reads never overlap a write strobe and happen inside a select window
    p_read_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (sram_we_n && !sram_cs_n && sram_cs && !sram_dq_oe));

    // R6: address stable across a select window
    p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

endmodule

// File: tb/sram_async_ctrl_test.sv
`timescale 1ns/1ps

module sram_bench_model #(
    parameter int T_NS  = 5,
    parameter int AA_NS = 55
) (
    input  logic        clk,
    input  logic [18:0] addr,
    input  logic        cs_n,
    input  logic        cs,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [7:0]  dq_o,
    input  logic        dq_oe,
    output logic [7:0]  dq_i
);
    logic [7:0] mem [256];
    int sel_len, we_len, oe_len, drv_len, drv_pre, drv_post, dstable, conflict, oe_in_write;
    int rcnt;
    bit sel_p, wr_p, we_seen;
    logic [7:0] wd_p, wa_p;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        sel_len = 0; we_len = 0; oe_len = 0; drv_len = 0; drv_pre = 0; drv_post = 0;
        dstable = 0; conflict = 0; oe_in_write = 0; rcnt = 0;
        sel_p = 0; wr_p = 0; we_seen = 0; wd_p = 0; wa_p = 0;
    end

    wire rd_now = !cs_n && cs && !oe_n && we_n;
    // Poisoned (inverted) data until the access time has elapsed
    assign dq_i = rd_now ? ((((rcnt + 1) * T_NS) >= AA_NS) ? mem[addr[7:0]] : ~mem[addr[7:0]]) : 8'h00;

    always @(posedge clk) begin
        bit sel, wr;
        sel = !cs_n && cs;
        wr  = sel && !we_n;
        if (sel && !sel_p) begin
            sel_len = 0; we_len = 0; oe_len = 0; drv_len = 0; drv_pre = 0;
            drv_post = 0; dstable = 0; oe_in_write = 0; we_seen = 0;
        end
        if (sel) sel_len++;
        if (sel && !oe_n) oe_len++;
        if (wr) begin
            we_len++;
            we_seen = 1;
            if (wr_p && dq_o == wd_p) dstable++; else dstable = 1;
            wd_p = dq_o;
            wa_p = addr[7:0];
            if (!oe_n) oe_in_write = 1;
        end
        if (dq_oe) begin
            drv_len++;
            if (!we_seen) drv_pre++;
            else if (we_n) drv_post++;
        end
        if (dq_oe && rd_now) conflict++;
        if (wr_p && !wr) mem[wa_p] = wd_p;
        if (rd_now) rcnt++; else rcnt = 0;
        sel_p = sel;
        wr_p  = wr;
    end
endmodule

module sram_async_ctrl_test;
    localparam int WATCHDOG_CYCLES = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_valid [2];
    logic        req_write [2];
    logic [18:0] req_addr  [2];
    logic [7:0]  req_wdata [2];
    logic        rdy       [2];
    logic        rvalid    [2];
    logic [7:0]  rdata     [2];
    logic [18:0] s_addr    [2];
    logic        s_cs_n    [2];
    logic        s_cs      [2];
    logic        s_we_n    [2];
    logic        s_oe_n    [2];
    logic [7:0]  s_dq_o    [2];
    logic        s_dq_oe   [2];
    logic [7:0]  s_dq_i    [2];

    sram_async_ctrl #(.CLK_PERIOD_NS(5), .SPEED_GRADE(0)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_ready(rdy[0]),
        .req_write(req_write[0]), .req_addr(req_addr[0]), .req_wdata(req_wdata[0]),
        .rd_valid(rvalid[0]), .rd_data(rdata[0]), .sram_addr(s_addr[0]),
        .sram_cs_n(s_cs_n[0]), .sram_cs(s_cs[0]), .sram_we_n(s_we_n[0]), .sram_oe_n(s_oe_n[0]),
        .sram_dq_o(s_dq_o[0]), .sram_dq_oe(s_dq_oe[0]), .sram_dq_i(s_dq_i[0]));

    sram_async_ctrl #(.CLK_PERIOD_NS(5), .SPEED_GRADE(1)) uut_slow (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_ready(rdy[1]),
        .req_write(req_write[1]), .req_addr(req_addr[1]), .req_wdata(req_wdata[1]),
        .rd_valid(rvalid[1]), .rd_data(rdata[1]), .sram_addr(s_addr[1]),
        .sram_cs_n(s_cs_n[1]), .sram_cs(s_cs[1]), .sram_we_n(s_we_n[1]), .sram_oe_n(s_oe_n[1]),
        .sram_dq_o(s_dq_o[1]), .sram_dq_oe(s_dq_oe[1]), .sram_dq_i(s_dq_i[1]));

    sram_bench_model #(.T_NS(5), .AA_NS(55)) mdl_fast (
        .clk(clk), .addr(s_addr[0]), .cs_n(s_cs_n[0]), .cs(s_cs[0]), .we_n(s_we_n[0]),
        .oe_n(s_oe_n[0]), .dq_o(s_dq_o[0]), .dq_oe(s_dq_oe[0]), .dq_i(s_dq_i[0]));

    sram_bench_model #(.T_NS(5), .AA_NS(70)) mdl_slow (
        .clk(clk), .addr(s_addr[1]), .cs_n(s_cs_n[1]), .cs(s_cs[1]), .we_n(s_we_n[1]),
        .oe_n(s_oe_n[1]), .dq_o(s_dq_o[1]), .dq_oe(s_dq_oe[1]), .dq_i(s_dq_i[1]));

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Expected phase lengths from the R9 tables at 5 ns
    function automatic int cyc(input int ns);
        int c;
        c = (ns + 4) / 5;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int e_nwp(input int g); return cyc(g ? 60 : 45); endfunction
    function automatic int e_nwc(input int g);
        int a;
        a = cyc(g ? 70 : 55);
        return (a > e_nwp(g) + 2) ? a : e_nwp(g) + 2;
    endfunction
    function automatic int e_nrd(input int g); return cyc(g ? 70 : 55); endfunction
    function automatic int e_nta(input int g); return cyc(g ? 25 : 20); endfunction

    localparam int K_SEL = 0, K_WE = 1, K_OE = 2, K_DRV = 3, K_PRE = 4, K_POST = 5,
                   K_DST = 6, K_CONF = 7, K_OEW = 8;
    function automatic int mval(input int g, input int k);
        if (g == 0) begin
            case (k)
                K_SEL: return mdl_fast.sel_len;  K_WE:  return mdl_fast.we_len;
                K_OE:  return mdl_fast.oe_len;   K_DRV: return mdl_fast.drv_len;
                K_PRE: return mdl_fast.drv_pre;  K_POST: return mdl_fast.drv_post;
                K_DST: return mdl_fast.dstable;  K_CONF: return mdl_fast.conflict;
                default: return mdl_fast.oe_in_write;
            endcase
        end else begin
            case (k)
                K_SEL: return mdl_slow.sel_len;  K_WE:  return mdl_slow.we_len;
                K_OE:  return mdl_slow.oe_len;   K_DRV: return mdl_slow.drv_len;
                K_PRE: return mdl_slow.drv_pre;  K_POST: return mdl_slow.drv_post;
                K_DST: return mdl_slow.dstable;  K_CONF: return mdl_slow.conflict;
                default: return mdl_slow.oe_in_write;
            endcase
        end
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int idle_pins(input int g);
        return int'(s_cs_n[g] && !s_cs[g] && s_we_n[g] && s_oe_n[g] && !s_dq_oe[g]);
    endfunction

    // Handshake; returns at the negedge after acceptance
    task automatic issue(input int g, input bit wr, input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!rdy[g]) @(negedge clk);
        req_valid[g] = 1'b1; req_write[g] = wr; req_addr[g] = a; req_wdata[g] = d;
        @(posedge clk);
        @(negedge clk);
        req_valid[g] = 1'b0;
        chk("R2 ready low when busy", int'(rdy[g]), 0);
        chk("R2 address registered", int'(s_addr[g]), int'(a));
        req_addr[g] = ~a; req_wdata[g] = ~d; req_write[g] = ~wr;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int g = 0; g < 2; g++) begin
            chk("R1 pins idle in reset", idle_pins(g), 1);
            chk("R1 rd_valid low in reset", int'(rvalid[g]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", int'(rdy[0]), 1);
    endtask

    task automatic t_idle(input int g);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R1 idle pins without request", idle_pins(g), 1);
            chk("R2 ready held in idle", int'(rdy[g]), 1);
        end
    endtask

    task automatic t_write(input int g, input logic [18:0] a, input logic [7:0] d);
        int busy;
        issue(g, 1'b1, a, d);
        busy = 1;
        forever begin
            @(negedge clk);
            if (rdy[g]) break;
            if (busy == 1) chk("R2 address ignores later req_addr", int'(s_addr[g]), int'(a));
            busy++;
        end
        chk(g ? "R9 R4 slow write window" : "R4 write window", busy, e_nwc(g));
        @(posedge clk); @(posedge clk); #1;
        chk(g ? "R9 R3 slow strobe length" : "R3 strobe length", mval(g, K_WE), e_nwp(g));
        chk("R4 select length", mval(g, K_SEL), e_nwc(g));
        chk("R3 output strobe high in write", mval(g, K_OEW), 0);
        chk("R5 driver one cycle before strobe", mval(g, K_PRE), 1);
        chk("R5 driver one cycle after strobe", mval(g, K_POST), 1);
        chk("R5 data stable across strobe", mval(g, K_DST), e_nwp(g));
        chk("R5 no bus conflict", mval(g, K_CONF), 0);
    endtask

    task automatic t_read(input int g, input logic [18:0] a, input logic [7:0] exp);
        int lat, turn;
        issue(g, 1'b0, a, 8'h00);
        lat = 1;
        while (!rvalid[g]) begin
            @(negedge clk);
            lat++;
        end
        chk(g ? "R9 R7 slow read latency" : "R7 read latency", lat, e_nrd(g) + 1);
        chk("R7 read data", int'(rdata[g]), int'(exp));
        chk(g ? "R9 R6 slow output strobe length" : "R6 output strobe length", mval(g, K_OE), e_nrd(g));
        chk("R8 deselected at rd_valid", idle_pins(g), 1);
        turn = 1;
        forever begin
            @(negedge clk);
            if (turn == 1) chk("R7 single-cycle rd_valid", int'(rvalid[g]), 0);
            if (rdy[g]) break;
            chk("R8 deselected during turnaround", idle_pins(g), 1);
            turn++;
        end
        chk(g ? "R9 R8 slow turnaround" : "R8 turnaround", turn, e_nta(g));
        chk("R5 no bus conflict on read", mval(g, K_CONF), 0);
    endtask

    initial begin
        for (int g = 0; g < 2; g++) begin
            req_valid[g] = 0; req_write[g] = 0; req_addr[g] = '0; req_wdata[g] = '0;
        end
        t_reset();
        t_idle(0);
        t_write(0, 19'h00012, 8'hA5);
        t_write(0, 19'h7FF34, 8'h5A);
        t_write(0, 19'h00000, 8'hFF);
        t_write(0, 19'h7FFFF, 8'h00);
        t_read(0, 19'h00012, 8'hA5);
        t_read(0, 19'h7FF34, 8'h5A);
        t_read(0, 19'h00000, 8'hFF);
        t_read(0, 19'h7FFFF, 8'h00);
        t_write(0, 19'h00012, 8'h3C);
        t_read(0, 19'h00012, 8'h3C);
        t_read(0, 19'h00012, 8'h3C);
        t_write(1, 19'h40077, 8'hC3);
        t_read(1, 19'h40077, 8'hC3);
        t_write(1, 19'h00001, 8'h81);
        t_read(1, 19'h00001, 8'h81);
        t_idle(1);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(WATCHDOG_CYCLES * 5);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule